// File: doc/BRIEF.md
# Machine Interrupt Pending and Arbitration

This block keeps the machine-level interrupt pending and enable state of a small in-order core, together with a timer compare value, and picks the interrupt that the core should take next. A free-running real-time count is compared against the compare value every cycle to raise the machine timer request. A strobe from another hart raises the machine software request. A host-message flag is a third machine-level source. The core writes the pending, enable and compare values through a one-word write port.

The arbitration uses the current privilege level and the global interrupt-enable bit to decide which level is allowed to interrupt. It then reports a registered take indication and a cause word whose top bit marks it as an interrupt. The core uses these outputs to start its trap sequence. Vectoring, flushing and the rest of the status registers live elsewhere.

Top module: `irq_pend_arb`

## Requirements
- R1: The machine timer pending bit (pending bit 7) becomes set in the cycle after any cycle in which the real-time input is greater than or equal to the stored compare value, and stays set until a compare write clears it.
- R2: A write with selector 2 loads the compare value from the write data and clears the machine timer pending bit in the same edge.
- R3: A high inter-processor strobe sets the machine software pending bit (pending bit 3), and it wins over a pending write in the same cycle.
- R4: Machine sources may interrupt when the privilege input is below machine (3), or when it is machine and the global enable is high.
- R5: Supervisor sources (software bit 1, timer bit 5) may interrupt only when privilege is user (0), or supervisor (1) with the global enable high.
- R6: Priority, highest first: machine software, machine timer, host message, supervisor software, supervisor timer.
- R7: A software or timer source competes only when both its pending and its enable bit are set; the host message needs no enable bit.
- R8: When taking an interrupt, the cause word has its MSB set and its low bits hold 0 for software, 1 for timer, 2 for host; with no interrupt the cause word is zero.
- R9: A write with selector 0 changes pending bits 1, 3 and 5 only; bit 7 cannot be set or cleared by it.
- R10: A write with selector 1 loads enable bits 1, 3, 5 and 7 from the write data; other bits stay zero.
- R11: After synchronous reset the take output is low, the cause is zero, all pending and enable bits are zero and the compare value is all ones.
- R12: The take and cause outputs are registered: they reflect the state and inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_i | input | TIME_W | Real-time count |
| ipi_i | input | 1 | Inter-processor interrupt strobe |
| host_msg_i | input | 1 | Host message present |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 2 | 0 pending, 1 enable, 2 compare |
| csr_wdata_i | input | TIME_W | Write data |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| gie_i | input | 1 | Global interrupt enable |
| irq_take_o | output | 1 | Take an interrupt |
| irq_cause_o | output | CAUSE_W | Cause word |

## Verification
The assertions assume the privilege input only uses the codes 0, 1, 2 and 3 and that the selector is one of 0, 1 or 2 whenever a write is strobed; a selector of 3 is treated as no write. The stimulus draws the selector only from the three legal values, keeps the real-time value and compare values in a small window so both compare outcomes occur often, and includes the reserved privilege code 2, which the block treats as below machine and above supervisor.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_W = 8;
  localparam int B_SSW = 1;
  localparam int B_MSW = 3;
  localparam int B_STM = 5;
  localparam int B_MTM = 7;
  localparam logic [IRQ_W-1:0] PEND_WMASK = 8'h2A;
  localparam logic [IRQ_W-1:0] ENA_WMASK  = 8'hAA;

  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_SW   = 4'd0;
  localparam logic [CODE_W-1:0] CODE_TMR  = 4'd1;
  localparam logic [CODE_W-1:0] CODE_HOST = 4'd2;

  typedef enum logic [1:0] {
    LVL_U = 2'd0,
    LVL_S = 2'd1,
    LVL_R = 2'd2,
    LVL_M = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_ENA  = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] rtc_i,
  input  logic              ipi_i,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [TIME_W-1:0] wdata_i,
  output logic [IRQ_W-1:0]  pend_o,
  output logic [IRQ_W-1:0]  ena_o,
  output logic [TIME_W-1:0] cmp_o
);
  logic [IRQ_W-1:0]  pend_q, pend_n;
  logic [IRQ_W-1:0]  ena_q, ena_n;
  logic [TIME_W-1:0] cmp_q, cmp_n;
  logic              wr_pend, wr_ena, wr_cmp, hit;

  assign wr_pend = we_i && (sel_i == SEL_PEND);
  assign wr_ena  = we_i && (sel_i == SEL_ENA);
  assign wr_cmp  = we_i && (sel_i == SEL_CMP);
  assign hit     = (rtc_i >= cmp_q);

  always_comb begin
    pend_n = pend_q;
    ena_n  = ena_q;
    cmp_n  = cmp_q;
    if (wr_pend)
      pend_n = (pend_q & ~PEND_WMASK) | (wdata_i[IRQ_W-1:0] & PEND_WMASK);
    if (ipi_i)
      pend_n[B_MSW] = 1'b1;
    if (wr_cmp) begin
      cmp_n         = wdata_i;
      pend_n[B_MTM] = 1'b0;
    end else if (hit) begin
      pend_n[B_MTM] = 1'b1;
    end
    if (wr_ena)
      ena_n = wdata_i[IRQ_W-1:0] & ENA_WMASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      ena_q  <= '0;
      cmp_q  <= '1;
    end else begin
      pend_q <= pend_n;
      ena_q  <= ena_n;
      cmp_q  <= cmp_n;
    end
  end

  assign pend_o = pend_q;
  assign ena_o  = ena_q;
  assign cmp_o  = cmp_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
(
  input  logic [IRQ_W-1:0]  pend_i,
  input  logic [IRQ_W-1:0]  ena_i,
  input  logic              host_i,
  input  logic [1:0]        priv_i,
  input  logic              gie_i,
  output logic              take_o,
  output logic [CODE_W-1:0] code_o
);
  logic [IRQ_W-1:0] act;
  logic             m_ok, s_ok;

  assign act  = pend_i & ena_i;
  assign m_ok = (priv_i != LVL_M) || gie_i;
  assign s_ok = (priv_i == LVL_U) || ((priv_i == LVL_S) && gie_i);

  always_comb begin
    take_o = 1'b1;
    code_o = CODE_SW;
    if (m_ok && act[B_MSW])      code_o = CODE_SW;
    else if (m_ok && act[B_MTM]) code_o = CODE_TMR;
    else if (m_ok && host_i)     code_o = CODE_HOST;
    else if (s_ok && act[B_SSW]) code_o = CODE_SW;
    else if (s_ok && act[B_STM]) code_o = CODE_TMR;
    else                         take_o = 1'b0;
  end
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb
  import irq_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter int CAUSE_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TIME_W-1:0]  rtc_i,
  input  logic               ipi_i,
  input  logic               host_msg_i,
  input  logic               csr_we_i,
  input  logic [1:0]         csr_sel_i,
  input  logic [TIME_W-1:0]  csr_wdata_i,
  input  logic [1:0]         priv_i,
  input  logic               gie_i,
  output logic               irq_take_o,
  output logic [CAUSE_W-1:0] irq_cause_o
);
  localparam int PAD_W = CAUSE_W - 1 - CODE_W;

  logic [IRQ_W-1:0]  pend_q, ena_q;
  logic [TIME_W-1:0] cmp_q;
  logic              take_c;
  logic [CODE_W-1:0] code_c;

  irq_state_regs #(.TIME_W(TIME_W)) u_regs (
    .clk(clk), .rst(rst), .rtc_i(rtc_i), .ipi_i(ipi_i),
    .we_i(csr_we_i), .sel_i(csr_sel_i), .wdata_i(csr_wdata_i),
    .pend_o(pend_q), .ena_o(ena_q), .cmp_o(cmp_q)
  );

  irq_prio_sel u_sel (
    .pend_i(pend_q), .ena_i(ena_q), .host_i(host_msg_i),
    .priv_i(priv_i), .gie_i(gie_i), .take_o(take_c), .code_o(code_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_take_o  <= 1'b0;
      irq_cause_o <= '0;
    end else begin
      irq_take_o  <= take_c;
      irq_cause_o <= take_c ? {1'b1, {PAD_W{1'b0}}, code_c} : '0;
    end
  end
endmodule

// File: rtl/irq_pend_arb_chk.sv
module irq_pend_arb_chk
  import irq_pkg::*;
#(
  parameter int TIME_W  = 64,
  parameter int CAUSE_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic [TIME_W-1:0]  rtc_i,
  input logic               ipi_i,
  input logic               host_msg_i,
  input logic               csr_we_i,
  input logic [1:0]         csr_sel_i,
  input logic [1:0]         priv_i,
  input logic               gie_i,
  input logic               irq_take_o,
  input logic [CAUSE_W-1:0] irq_cause_o,
  input logic [IRQ_W-1:0]   pend_q,
  input logic [IRQ_W-1:0]   ena_q,
  input logic [TIME_W-1:0]  cmp_q
);
  logic cmp_wr;
  assign cmp_wr = csr_we_i && (csr_sel_i == SEL_CMP);

  p_timer_set_r1: assert property (@(posedge clk) disable iff (rst)
    (!cmp_wr && (rtc_i >= cmp_q)) |=> pend_q[B_MTM]);

  p_timer_rise_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q[B_MTM]) |-> $past(rtc_i >= cmp_q));

  p_cmp_clears_r2: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> !pend_q[B_MTM]);

  p_ipi_sets_r3: assert property (@(posedge clk) disable iff (rst)
    ipi_i |=> pend_q[B_MSW]);

  p_machine_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (priv_i == LVL_M && !gie_i) |=> !irq_take_o);

  p_enable_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (ena_q == '0 && !host_msg_i) |=> !irq_take_o);

  p_cause_msb_r8: assert property (@(posedge clk) disable iff (rst)
    irq_take_o |-> irq_cause_o[CAUSE_W-1]);

  p_cause_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_take_o |-> (irq_cause_o == '0));

  p_enable_mask_r10: assert property (@(posedge clk) disable iff (rst)
    (ena_q & ~ENA_WMASK) == '0);
endmodule

bind irq_pend_arb irq_pend_arb_chk #(.TIME_W(TIME_W), .CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst(rst), .rtc_i(rtc_i), .ipi_i(ipi_i), .host_msg_i(host_msg_i),
  .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i), .priv_i(priv_i), .gie_i(gie_i),
  .irq_take_o(irq_take_o), .irq_cause_o(irq_cause_o),
  .pend_q(pend_q), .ena_q(ena_q), .cmp_q(cmp_q)
);

// File: tb/irq_pend_arb_test.sv
module irq_pend_arb_test;
  localparam int TW = 64;
  localparam int CW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] rtc = '0;
  logic          ipi = 1'b0, host = 1'b0, we = 1'b0, gie = 1'b0;
  logic [1:0]    sel = 2'd3, priv = 2'd0;
  logic [TW-1:0] wdata = '0;
  logic          take;
  logic [CW-1:0] cause;

  int n_chk = 0, n_fail = 0;

  logic [7:0]    m_pend, m_ena;
  logic [TW-1:0] m_cmp;
  logic          e_take;
  logic [CW-1:0] e_cause;

  irq_pend_arb #(.TIME_W(TW), .CAUSE_W(CW)) uut (
    .clk(clk), .rst(rst), .rtc_i(rtc), .ipi_i(ipi), .host_msg_i(host),
    .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata), .priv_i(priv),
    .gie_i(gie), .irq_take_o(take), .irq_cause_o(cause)
  );

  always #10 clk = ~clk;

  function automatic logic [CW:0] expect_out(input logic [7:0] p, input logic [7:0] e,
                                              input logic h, input logic [1:0] pv, input logic g);
    logic [7:0] a;
    logic mo, so;
    a  = p & e;
    mo = (pv < 2'd3) || g;
    so = (pv == 2'd0) || (pv == 2'd1 && g);
    if (mo && a[3])      return {1'b1, 1'b1, 63'd0};
    else if (mo && a[7]) return {1'b1, 1'b1, 63'd1};
    else if (mo && h)    return {1'b1, 1'b1, 63'd2};
    else if (so && a[1]) return {1'b1, 1'b1, 63'd0};
    else if (so && a[5]) return {1'b1, 1'b1, 63'd1};
    return '0;
  endfunction

  task automatic check(input string lbl, input logic t, input logic [CW-1:0] c);
    n_chk++;
    if (take !== t || cause !== c) begin
      n_fail++;
      $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h", lbl, take, cause, t, c);
    end
  endtask

  task automatic step(input string lbl);
    {e_take, e_cause} = expect_out(m_pend, m_ena, host, priv, gie);
    if (we && sel == 2'd0) m_pend = (m_pend & ~8'h2A) | (wdata[7:0] & 8'h2A);
    if (ipi) m_pend[3] = 1'b1;
    if (we && sel == 2'd2) begin m_cmp = wdata; m_pend[7] = 1'b0; end
    else if (rtc >= m_cmp) m_pend[7] = 1'b1;
    if (we && sel == 2'd1) m_ena = wdata[7:0] & 8'hAA;
    @(posedge clk);
    @(negedge clk);
    check(lbl, e_take, e_cause);
    we = 1'b0; ipi = 1'b0; sel = 2'd3;
  endtask

  task automatic wr(input logic [1:0] s, input logic [TW-1:0] d, input string lbl);
    we = 1'b1; sel = s; wdata = d;
    step(lbl);
  endtask

  initial begin
    #4_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset", 1'b0, '0);
    rst = 1'b0;
    m_pend = '0; m_ena = '0; m_cmp = '1;

    step("R11 idle after reset");
    wr(2'd1, 64'hFF, "R10 enable write");
    wr(2'd0, 64'hFF, "R9 pending write");
    step("R6 R12 software first");
    wr(2'd0, 64'h00, "R9 clear pending");
    step("R9 timer bit not writable");
    rtc = 64'd20;
    wr(2'd2, 64'd10, "R2 compare write");
    step("R1 timer raised");
    rtc = 64'd5;
    step("R1 timer held");
    ipi = 1'b1; host = 1'b1;
    wr(2'd0, 64'h22, "R3 strobe beats write");
    step("R6 all pending software wins");
    wr(2'd0, 64'h22, "R6 drop software");
    step("R6 timer next");
    wr(2'd2, 64'd100, "R2 clear timer");
    step("R6 host next");
    host = 1'b0;
    step("R6 supervisor software");
    priv = 2'd3; gie = 1'b0;
    step("R4 machine masked");
    priv = 2'd1; gie = 1'b0;
    step("R5 supervisor masked");
    gie = 1'b1;
    step("R5 supervisor enabled");
    wr(2'd1, 64'h00, "R7 disable all");
    host = 1'b1; priv = 2'd2;
    step("R7 host needs no enable");
    priv = 2'd3; gie = 1'b1;
    step("R4 machine enabled");
    host = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      rtc  = 64'($urandom_range(0, 63));
      ipi  = ($urandom_range(0, 7) == 0);
      host = ($urandom_range(0, 7) == 0);
      priv = 2'($urandom_range(0, 3));
      gie  = 1'($urandom_range(0, 1));
      if (r < 4'd6) begin
        we = 1'b1;
        sel = 2'($urandom_range(0, 2));
        wdata = (sel == 2'd2) ? 64'($urandom_range(0, 63)) : 64'($urandom);
      end
      step("R6 R7 R8 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule